// File: doc/BRIEF.md
# Byte Multiply/Divide Unit

This block runs unsigned 8-by-8 multiplication and unsigned 8-by-8 division for an accumulator-style datapath. A single-clock `start` pulse captures an operation select and two operand bytes, called A and B. A fixed number of machine cycles later the unit raises `done` for one clock. At that point it presents two result bytes, a carry flag and an overflow flag.

The arithmetic is bit-serial. The multiplier shifts and adds one bit per clock, and the divider restores one bit per clock. Both finish long before the completion point. The completion point depends only on the timing parameters, never on the operand values. A machine cycle lasts a programmable number of clocks, so the same unit can follow slow instruction timing or run quickly in simulation.

Top module: `byte_muldiv`

## Requirements
- R1: For a multiply (`op_sel`=0), `res_a` holds bits 7:0 and `res_b` holds bits 15:8 of the unsigned product of `a_in` and `b_in`.
- R2: After a multiply, `ov` is 1 exactly when the product is greater than 255, and 0 otherwise.
- R3: `cy` is 0 after every completed multiply and every completed divide.
- R4: For a divide (`op_sel`=1) with a nonzero divisor, `res_a` holds the unsigned quotient `a_in / b_in` and `res_b` holds the remainder.
- R5: A divide with a nonzero divisor leaves `ov` at 0.
- R6: A divide by zero sets `ov` to 1 and returns the operands unchanged: `res_a` equals `a_in` and `res_b` equals 0.
- R7: `done` rises exactly MC_COUNT×CLKS_PER_MC clocks after the clock edge that accepted `start`, and it lasts exactly one clock.
- R8: A `start` pulse while `busy` is 1 is ignored. Neither the results nor the completion time of the running operation change.
- R9: `res_a`, `res_b`, `cy` and `ov` hold their values from one `done` pulse to the next, even when the operand inputs change.
- R10: After reset, `res_a`, `res_b`, `cy`, `ov`, `done` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | W | Operand A (multiplicand or dividend) |
| b_in | input | W | Operand B (multiplier or divisor) |
| res_a | output | W | Low product byte, or quotient |
| res_b | output | W | High product byte, or remainder |
| cy | output | 1 | Carry flag, cleared on completion |
| ov | output | 1 | Overflow flag: product above 255, or divisor of zero |
| done | output | 1 | One-clock completion strobe |
| busy | output | 1 | High while an operation is running |

## Verification
The bench builds the unit with W=8, MC_COUNT=4 and CLKS_PER_MC=3. This gives a 12-clock operation window, which is still longer than the 8 clocks the serial datapath needs. Each operation completes quickly with these values, so several hundred random operations fit in a short run. Directed cases alongside them cover the product exactly at 255 and 256, full-scale operands, zero divisors, a dividend smaller than the divisor, and a second start request arriving mid-operation. With the default of 12 clocks per machine cycle, the same behaviour takes four times as many clocks per operation.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/md_cycle_timer.sv
`timescale 1ns/1ps
// Counts a fixed window of MC_COUNT machine cycles of CLKS_PER_MC clocks each.
module md_cycle_timer #(
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic running,
    output logic expire
);
    localparam int CW = $clog2(CLKS_PER_MC + 1);
    localparam int MW = $clog2(MC_COUNT + 1);
    localparam logic [CW-1:0] CLK_LAST = CW'(CLKS_PER_MC - 1);
    localparam logic [MW-1:0] MC_LAST  = MW'(MC_COUNT - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] clk_cnt;
        logic [MW-1:0] mc_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic clk_wrap, mc_wrap;

    always_comb begin
        tmr_d    = tmr_q;
        clk_wrap = (tmr_q.clk_cnt == CLK_LAST);
        mc_wrap  = (tmr_q.mc_cnt == MC_LAST);
        if (!tmr_q.run) begin
            if (launch) begin
                tmr_d.run     = 1'b1;
                tmr_d.clk_cnt = '0;
                tmr_d.mc_cnt  = '0;
            end
        end else if (clk_wrap) begin
            tmr_d.clk_cnt = '0;
            if (mc_wrap) tmr_d.run = 1'b0;
            else         tmr_d.mc_cnt = tmr_q.mc_cnt + 1'b1;
        end else begin
            tmr_d.clk_cnt = tmr_q.clk_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign running = tmr_q.run;
    assign expire  = tmr_q.run && clk_wrap && mc_wrap;
endmodule

// File: rtl/md_mul_core.sv
`timescale 1ns/1ps
// Shift-add multiplier: one multiplier bit per step.
module md_mul_core #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] product
);
    typedef struct packed {
        logic [W-1:0]   mcand;
        logic [2*W-1:0] acc;
    } mul_t;

    mul_t mul_d, mul_q;
    logic [W:0] partial;

    always_comb begin
        mul_d   = mul_q;
        partial = {1'b0, mul_q.acc[2*W-1:W]} +
                  (mul_q.acc[0] ? {1'b0, mul_q.mcand} : '0);
        if (load) begin
            mul_d.mcand = mcand_in;
            mul_d.acc   = {{W{1'b0}}, mplier_in};
        end else if (step) begin
            mul_d.acc = {partial, mul_q.acc[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mul_q <= '0;
        else        mul_q <= mul_d;
    end

    assign product = mul_q.acc;
endmodule

// File: rtl/md_div_core.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per step.
module md_div_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    typedef struct packed {
        logic [W-1:0] dsr;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
    } div_t;

    div_t div_d, div_q;
    logic [W:0]   shifted;
    logic [W+1:0] trial;

    always_comb begin
        div_d   = div_q;
        shifted = {div_q.rem, div_q.quo[W-1]};
        trial   = {1'b0, shifted} - {2'b00, div_q.dsr};
        if (load) begin
            div_d.dsr = divisor_in;
            div_d.rem = '0;
            div_d.quo = dividend_in;
        end else if (step) begin
            if (!trial[W+1]) begin
                div_d.rem = trial[W-1:0];
                div_d.quo = {div_q.quo[W-2:0], 1'b1};
            end else begin
                div_d.rem = shifted[W-1:0];
                div_d.quo = {div_q.quo[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign quotient  = div_q.quo;
    assign remainder = div_q.rem;
endmodule

// File: rtl/byte_muldiv.sv
`timescale 1ns/1ps
module byte_muldiv
    import muldiv_pkg::*;
#(
    parameter int W           = 8,
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_b,
    output logic         cy,
    output logic         ov,
    output logic         done,
    output logic         busy
);
    localparam int SW = $clog2(W + 1);
    localparam logic [SW-1:0] STEPS = SW'(W);

    typedef struct packed {
        md_op_e        op;
        logic [SW-1:0] step;
        logic [W-1:0]  opa;
        logic [W-1:0]  opb;
        logic [W-1:0]  ra;
        logic [W-1:0]  rb;
        logic          cy;
        logic          ov;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic           accept, step_en, expire, running;
    logic [2*W-1:0] product;
    logic [W-1:0]   quotient, remainder;

    assign accept  = start && !running;
    assign step_en = running && (ctl_q.step < STEPS);

    md_cycle_timer #(.CLKS_PER_MC(CLKS_PER_MC), .MC_COUNT(MC_COUNT)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(accept),
        .running(running), .expire(expire)
    );

    md_mul_core #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(step_en),
        .mcand_in(a_in), .mplier_in(b_in), .product(product)
    );

    md_div_core #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(step_en),
        .dividend_in(a_in), .divisor_in(b_in),
        .quotient(quotient), .remainder(remainder)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) begin
            ctl_d.op   = md_op_e'(op_sel);
            ctl_d.opa  = a_in;
            ctl_d.opb  = b_in;
            ctl_d.step = '0;
        end else if (step_en) begin
            ctl_d.step = ctl_q.step + 1'b1;
        end
        if (expire) begin
            ctl_d.done = 1'b1;
            ctl_d.cy   = 1'b0;
            if (ctl_q.op == OP_MUL) begin
                ctl_d.ra = product[W-1:0];
                ctl_d.rb = product[2*W-1:W];
                ctl_d.ov = |product[2*W-1:W];
            end else if (ctl_q.opb == '0) begin
                ctl_d.ra = ctl_q.opa;
                ctl_d.rb = ctl_q.opb;
                ctl_d.ov = 1'b1;
            end else begin
                ctl_d.ra = quotient;
                ctl_d.rb = remainder;
                ctl_d.ov = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign res_a = ctl_q.ra;
    assign res_b = ctl_q.rb;
    assign cy    = ctl_q.cy;
    assign ov    = ctl_q.ov;
    assign done  = ctl_q.done;
    assign busy  = running;
endmodule

// File: rtl/byte_muldiv_chk.sv
`timescale 1ns/1ps
module byte_muldiv_chk #(
    parameter int W           = 8,
    parameter int CLKS_PER_MC = 12,
    parameter int MC_COUNT    = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_sel,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] res_a,
    input logic [W-1:0] res_b,
    input logic         cy,
    input logic         ov,
    input logic         done,
    input logic         busy
);
    localparam int LAT = CLKS_PER_MC * MC_COUNT;

    logic           run_q, cap_op;
    int             cnt_q;
    logic [W-1:0]   cap_a, cap_b, exp_q, exp_r;
    logic [2*W-1:0] exp_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0; cnt_q <= 0; cap_op <= 1'b0; cap_a <= '0; cap_b <= '0;
        end else if (start && !busy) begin
            run_q <= 1'b1; cnt_q <= 0; cap_op <= op_sel; cap_a <= a_in; cap_b <= b_in;
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1;
        end
    end

    always_comb begin
        exp_p = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
        exp_q = (cap_b == '0) ? '0 : cap_a / cap_b;
        exp_r = (cap_b == '0) ? '0 : cap_a % cap_b;
    end

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q && cnt_q == LAT));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_op) |-> ({res_b, res_a} == exp_p));
    // R2
    mul_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_op) |-> (ov == (exp_p > 2*W'(0) + (1 << W) - 1)));
    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cy);
    // R4
    div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op && cap_b != '0) |-> (res_a == exp_q && res_b == exp_r));
    // R5
    div_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op && cap_b != '0) |-> !ov);
    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op && cap_b == '0) |-> (ov && res_a == cap_a && res_b == '0));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_a) && $stable(res_b) && $stable(ov) && $stable(cy)));
endmodule

bind byte_muldiv byte_muldiv_chk #(
    .W(W), .CLKS_PER_MC(CLKS_PER_MC), .MC_COUNT(MC_COUNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .a_in(a_in), .b_in(b_in), .res_a(res_a), .res_b(res_b),
    .cy(cy), .ov(ov), .done(done), .busy(busy)
);

// File: tb/byte_muldiv_bench.sv
`timescale 1ns/1ps
module byte_muldiv_bench;
    localparam int W    = 8;
    localparam int CPM  = 3;
    localparam int MCS  = 4;
    localparam int LAT  = CPM * MCS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sel = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] res_a, res_b;
    logic         cy, ov, done, busy;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    byte_muldiv #(.W(W), .CLKS_PER_MC(CPM), .MC_COUNT(MCS)) u_byte_muldiv (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .a_in(a_in), .b_in(b_in), .res_a(res_a), .res_b(res_b),
        .cy(cy), .ov(ov), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3*W:0] model(input logic op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        if (!op) begin
            p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
            return {p > 255, p[2*W-1:W], p[W-1:0], {W{1'b0}}};
        end else if (b == 0) begin
            return {1'b1, {W{1'b0}}, a, {W{1'b0}}};
        end else begin
            return {1'b0, W'(a % b), W'(a / b), {W{1'b0}}};
        end
    endfunction

    task automatic run_op(input logic op, input logic [W-1:0] a, input logic [W-1:0] b, input bit meddle);
        int cnt;
        logic [3*W:0] e;
        logic [W-1:0] ea, eb;
        logic eov;
        string tag_a, tag_b, tag_o;
        e = model(op, a, b);
        eov = e[3*W]; eb = e[3*W-1:2*W]; ea = e[2*W-1:W];
        if (!op) begin tag_a = "R1"; tag_b = "R1"; tag_o = "R2"; end
        else if (b == 0) begin tag_a = "R6"; tag_b = "R6"; tag_o = "R6"; end
        else begin tag_a = "R4"; tag_b = "R4"; tag_o = "R5"; end
        @(negedge clk);
        start = 1'b1; op_sel = op; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0; a_in = ~a; b_in = b ^ 8'h5A;
        cnt = 1;
        if (meddle) begin
            // R8: second request while running must be ignored
            chk(busy == 1'b1, "R8 busy", busy, 1);
            start = 1'b1; op_sel = ~op; a_in = a + 8'd3; b_in = 8'd0;
            @(negedge clk); cnt++;
            start = 1'b0;
        end
        while (!done && cnt < 4 * LAT) begin
            @(negedge clk); cnt++;
        end
        chk(cnt - 1 == LAT, meddle ? "R8 latency" : "R7 latency", cnt - 1, LAT);
        chk(res_a == ea, tag_a, res_a, ea);
        chk(res_b == eb, tag_b, res_b, eb);
        chk(ov == eov, tag_o, ov, eov);
        chk(cy == 1'b0, "R3", cy, 0);
        a_in = $urandom; b_in = $urandom; op_sel = $urandom;
        @(negedge clk);
        chk(done == 1'b0, "R7 pulse width", done, 0);
        chk(res_a == ea && res_b == eb && ov == eov, "R9", res_a, ea);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(res_a == 0 && res_b == 0, "R10 results", res_a, 0);
        chk(cy == 0 && ov == 0, "R10 flags", ov, 0);
        chk(done == 0 && busy == 0, "R10 strobes", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_a == 0 && done == 0 && busy == 0, "R10 after release", res_a, 0);

        run_op(1'b0, 8'd255, 8'd255, 1'b0);
        run_op(1'b0, 8'd0,   8'd201, 1'b0);
        run_op(1'b0, 8'd16,  8'd16,  1'b0);
        run_op(1'b0, 8'd15,  8'd17,  1'b0);
        run_op(1'b0, 8'd1,   8'd255, 1'b0);
        run_op(1'b1, 8'd255, 8'd1,   1'b0);
        run_op(1'b1, 8'd7,   8'd9,   1'b0);
        run_op(1'b1, 8'd0,   8'd5,   1'b0);
        run_op(1'b1, 8'd200, 8'd0,   1'b0);
        run_op(1'b1, 8'd0,   8'd0,   1'b0);
        run_op(1'b1, 8'd255, 8'd255, 1'b0);
        run_op(1'b1, 8'd254, 8'd255, 1'b0);
        run_op(1'b0, 8'd123, 8'd45,  1'b1);
        run_op(1'b1, 8'd99,  8'd0,   1'b1);

        for (int i = 0; i < 250; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = ($urandom % 16 == 0) ? 8'd0 : 8'($urandom);
            run_op(1'($urandom), ra, rb, ($urandom % 8) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule